// File: doc/BRIEF.md
# Block-Transfer Configuration Slave for a Clock Generator

This block is a slave-only two-wire serial port that holds seven 8-bit configuration bytes for a clock generator. The bus has no register addressing. A write transfer always begins with two header bytes, which the slave acknowledges and throws away. The data bytes that follow fill the registers from index 0 upward. A read transfer always returns a byte count first and then the registers, starting at index 0.

The system clock samples SCL and SDA after a two-stage synchroniser. This clock must run at least ten times faster than the bus bit rate. The bus runs in standard mode, 100 kbit/s or slower. SDA is driven through an open-drain enable: when `sda_oe` is high, the pad pulls the line low. The bus has no data stream with back-pressure, and the block does not stretch the clock. The configuration image is a plain, always-valid output vector. Byte k of that vector sits at bits [8k+7:8k].

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset the image holds the bytes 0x5A, 0x00, 0xFF, 0xEF, 0x00, 0x3F and 0x06, for register 0 through register 6 in that order.
- R2: The slave acknowledges the address byte 0xD2 (write) and the address byte 0xD3 (read) by pulling SDA low in the ninth bit. For any other address byte it gives no acknowledge, keeps SDA released and changes no register until the next start condition.
- R3: In a write, the two bytes after the address are acknowledged and their values are discarded. Each later data byte is acknowledged and lands in the next register, starting at register 0 whatever the header values were. A transfer stopped after only a header byte changes nothing.
- R4: A stop after any complete byte ends the write. Registers written in that transfer keep their new values, and all other registers keep their previous values.
- R5: Data bytes after the seventh data byte of a write are acknowledged and dropped.
- R6: In a read, the slave first sends the count 7 and then registers 0 to 6, most significant bit first. It moves to the next byte after each acknowledge from the master. Bytes requested after register 6 read as 0xFF.
- R7: When the master does not acknowledge a read byte, the slave releases SDA and keeps it released until the next start condition.
- R8: The slave changes SDA only while SCL is low. It recognises a start (SDA falling) or a stop (SDA rising) only while SCL is high. A start always re-arms address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the bus bit rate |
| rst_n | input | 1 | Active-low asynchronous reset; loads the default image |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| cfg_image | output | NUM_REGS*8 | Configuration bytes; byte k at bits [8k+7:8k] |

## Verification
A corrupted byte counter shows up at the ports as a data byte landing in the wrong register. The next full read-back exposes this, and so does the image port as soon as the stop bit ends. A transfer state that is stuck or out of step shows up as a missing or extra acknowledge within nine bus clocks of the fault. It can also show up as SDA held low after a master NACK, which is seen on the very next clocked bit. Each random write is followed by a read that compares all seven bytes and the count, so no stale or misplaced value survives more than one transaction.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_TX, ST_RD_ACK, ST_DONE
  } link_state_t;

  localparam int HDR_BYTES = 2;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_cond,
  output logic stop_cond
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_sy, sda_sy;
  logic         scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[MSB-1:0], scl_in};
      sda_sy <= {sda_sy[MSB-1:0], sda_in};
      scl_d  <= scl_sy[MSB];
      sda_d  <= sda_sy[MSB];
    end
  end

  assign scl_lvl    = scl_sy[MSB];
  assign sda_lvl    = sda_sy[MSB];
  assign scl_rise   = scl_lvl & ~scl_d;
  assign scl_fall   = ~scl_lvl & scl_d;
  // bus conditions only count while SCL stays high across the SDA edge (R8)
  assign start_cond = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_cond  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int                      NUM_REGS    = 7,
  parameter int                      IDX_W       = 3,
  parameter logic [NUM_REGS*8-1:0]   RESET_IMAGE = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [7:0]              wr_data,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [7:0]              rd_data,
  output logic [NUM_REGS*8-1:0]   image
);
  logic [7:0] regs_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] INIT = RESET_IMAGE[8*i +: 8];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   regs_q[i] <= INIT;
      else if (wr_en && (wr_idx == IDX_W'(i)))      regs_q[i] <= wr_data;
    end

    assign image[8*i +: 8] = regs_q[i];

    // a register not addressed by this cycle's strobe keeps its value (R4)
    assert_hold_unaddressed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (wr_idx == IDX_W'(i))) |=> $stable(regs_q[i]));
  end

  always_comb begin
    rd_data = 8'hFF;
    for (int k = 0; k < NUM_REGS; k++)
      if (rd_idx == IDX_W'(k)) rd_data = regs_q[k];
  end
endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
  import cfgi2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NUM_REGS = 7,
  parameter int         IDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_cond,
  input  logic              stop_cond,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [7:0]        wr_data,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [7:0]        rd_data
);
  localparam int CNT_W = $clog2(NUM_REGS + HDR_BYTES + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  link_state_t      state;
  logic [7:0]       shreg;
  logic [2:0]       bit_cnt;
  logic             rx_full, rd_mode, nack;
  logic [CNT_W-1:0] byte_cnt;
  logic [7:0]       tx_byte;
  logic             wr_in_range;
  logic [CNT_W-1:0] cnt_next;

  assign cnt_next    = (byte_cnt == CNT_MAX) ? byte_cnt : byte_cnt + CNT_W'(1);
  assign wr_in_range = (byte_cnt >= CNT_W'(HDR_BYTES)) &&
                       (byte_cnt <  CNT_W'(HDR_BYTES + NUM_REGS));
  assign wr_idx      = IDX_W'(byte_cnt - CNT_W'(HDR_BYTES));
  assign wr_data     = shreg;
  assign wr_en       = (state == ST_WR) && scl_fall && rx_full && wr_in_range;
  assign rd_idx      = IDX_W'(byte_cnt - CNT_W'(1));

  always_comb begin
    if (byte_cnt == '0)                       tx_byte = 8'(NUM_REGS);
    else if (byte_cnt <= CNT_W'(NUM_REGS))    tx_byte = rd_data;
    else                                      tx_byte = 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      bit_cnt  <= '0;
      rx_full  <= 1'b0;
      rd_mode  <= 1'b0;
      nack     <= 1'b0;
      byte_cnt <= '0;
      sda_oe   <= 1'b0;
    end else if (start_cond) begin
      state    <= ST_ADDR;
      bit_cnt  <= '0;
      rx_full  <= 1'b0;
      byte_cnt <= '0;
      sda_oe   <= 1'b0;
    end else if (stop_cond) begin
      state    <= ST_IDLE;
      sda_oe   <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_WR: begin
          if (scl_rise) begin
            shreg   <= {shreg[6:0], sda_lvl};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) rx_full <= 1'b1;
          end else if (scl_fall && rx_full) begin
            rx_full <= 1'b0;
            bit_cnt <= '0;
            if (state == ST_ADDR) begin
              if (shreg[7:1] == DEV_ADDR) begin
                sda_oe  <= 1'b1;
                rd_mode <= shreg[0];
                state   <= ST_ADDR_ACK;
              end else begin
                state   <= ST_DONE;
              end
            end else begin
              sda_oe   <= 1'b1;
              byte_cnt <= cnt_next;
              state    <= ST_WR_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rd_mode) begin
              shreg    <= tx_byte;
              sda_oe   <= ~tx_byte[7];
              bit_cnt  <= '0;
              byte_cnt <= cnt_next;
              state    <= ST_TX;
            end else begin
              sda_oe   <= 1'b0;
              state    <= ST_WR;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_WR;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt == 3'd7) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              state   <= ST_RD_ACK;
            end else begin
              sda_oe  <= ~shreg[6];
              shreg   <= {shreg[6:0], 1'b0};
              bit_cnt <= bit_cnt + 3'd1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            nack <= sda_lvl;
          end else if (scl_fall) begin
            if (nack) begin
              state <= ST_DONE;
            end else begin
              shreg    <= tx_byte;
              sda_oe   <= ~tx_byte[7];
              bit_cnt  <= '0;
              byte_cnt <= cnt_next;
              state    <= ST_TX;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // the address acknowledge is driven for the whole ninth bit (R2)
  assert_addr_ack_driven_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR_ACK) |-> sda_oe);

  // no drive while idle or after a NACK / foreign address (R7)
  assert_released_when_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_DONE) || (state == ST_IDLE)) |-> !sda_oe);

  // SDA drive never moves while SCL stays high (R8)
  assert_sda_stable_scl_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe));

  // a detected start re-arms address reception (R8)
  assert_start_rearms_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_cond |=> (state == ST_ADDR));
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter logic [6:0]             DEV_ADDR    = 7'h69,
  parameter int                     NUM_REGS    = 7,
  parameter int                     SYNC_STAGES = 2,
  parameter logic [NUM_REGS*8-1:0]  RESET_IMAGE = 56'h06_3F_00_EF_FF_00_5A
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_in,
  input  logic                   sda_in,
  output logic                   sda_oe,
  output logic [NUM_REGS*8-1:0]  cfg_image
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_cond, stop_cond;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0]       wr_data, rd_data;

  i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_cond(start_cond), .stop_cond(stop_cond)
  );

  i2c_link_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_cond(start_cond),
    .stop_cond(stop_cond), .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  cfg_reg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .RESET_IMAGE(RESET_IMAGE)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .image(cfg_image)
  );
endmodule

// File: tb/tb_cfg_i2c_slave.sv
module tb_cfg_i2c_slave;
  localparam int NREG = 7;
  localparam int Q    = 10;  // quarter bit period in system clocks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] cfg_image;
  wire  sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_bad = 0, oe_glitch = 0;
  logic [7:0] exp_r [NREG];
  logic [7:0] wbuf [16];
  logic prev_oe = 1'b0, prev_scl = 1'b1;

  always #2 clk = ~clk;

  cfg_i2c_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe(sda_oe), .cfg_image(cfg_image)
  );

  // R8: count drive changes seen while the master holds SCL high
  always @(negedge clk) begin
    if (rst_n && scl_m && prev_scl && (sda_oe !== prev_oe)) oe_glitch++;
    prev_oe  = sda_oe;
    prev_scl = scl_m;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dflt(input int i);
    logic [7:0] t [NREG] = '{8'h5A, 8'h00, 8'hFF, 8'hEF, 8'h00, 8'h3F, 8'h06};
    return t[i];
  endfunction

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait(); qwait();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qwait();
    scl_m = 1'b1; qwait(); qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    b = sda_line; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic wbyte(input logic [7:0] d, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(a);
    acked = !a;
  endtask

  task automatic rbyte(output logic [7:0] d, input bit give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
    send_bit(!give_ack);
  endtask

  task automatic check_image(input string tag);
    for (int i = 0; i < NREG; i++)
      chk(cfg_image[8*i +: 8] == exp_r[i], tag, cfg_image[8*i +: 8], exp_r[i]);
  endtask

  // write n data bytes from wbuf behind two random header bytes
  task automatic wr_xfer(input int n);
    bit a;
    bus_start();
    wbyte(8'hD2, a);                 chk(a, "R2 write address ack", a, 1);
    wbyte(8'($urandom), a);          chk(a, "R3 command byte ack", a, 1);
    wbyte(8'($urandom), a);          chk(a, "R3 count byte ack", a, 1);
    for (int i = 0; i < n; i++) begin
      wbyte(wbuf[i], a);
      chk(a, (i < NREG) ? "R3 data byte ack" : "R5 overflow byte ack", a, 1);
      if (i < NREG) exp_r[i] = wbuf[i];
    end
    bus_stop();
  endtask

  // read count plus nread registers; NACK on the last byte read
  task automatic rd_xfer(input int nread, input string tag);
    bit a;
    logic [7:0] d;
    bus_start();
    wbyte(8'hD3, a);                 chk(a, "R2 read address ack", a, 1);
    rbyte(d, nread > 0);             chk(d == 8'd7, "R6 byte count", d, 7);
    for (int i = 0; i < nread; i++) begin
      rbyte(d, i < nread - 1);
      if (i < NREG) chk(d == exp_r[i], tag, d, exp_r[i]);
      else          chk(d == 8'hFF, "R6 read past end", d, 8'hFF);
    end
    bus_stop();
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NREG; i++) exp_r[i] = dflt(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: defaults at the port and over the bus
    check_image("R1 reset image");
    rd_xfer(NREG, "R1 reset read-back");

    // R3: full write, random headers ignored, lands from reg 0
    for (int i = 0; i < NREG; i++) wbuf[i] = 8'($urandom);
    wr_xfer(NREG);
    check_image("R3 full write image");
    rd_xfer(NREG, "R3 full write read-back");

    // R3: header only, then stop -> nothing changes
    begin
      bit a;
      bus_start();
      wbyte(8'hD2, a); chk(a, "R2 write address ack", a, 1);
      wbyte(8'h04, a); chk(a, "R3 lone command ack", a, 1);
      bus_stop();
      check_image("R3 header-only no change");
    end

    // R5: ten data bytes, extras dropped
    for (int i = 0; i < 10; i++) wbuf[i] = 8'($urandom);
    wr_xfer(10);
    check_image("R5 overflow image");
    rd_xfer(9, "R6 read with overrun");

    // R2: foreign address ignored
    begin
      bit a;
      bus_start();
      wbyte(8'hA0, a); chk(!a, "R2 foreign address no ack", a, 0);
      for (int i = 0; i < 3; i++) begin
        wbyte(8'h00, a); chk(!a, "R2 foreign data no ack", a, 0);
      end
      bus_stop();
      check_image("R2 foreign address no change");
    end

    // R7: NACK after third register, line stays released
    rd_xfer(3, "R6 short read");
    begin
      bit a;
      logic b;
      logic [7:0] d;
      bus_start();
      wbyte(8'hD3, a); chk(a, "R2 read address ack", a, 1);
      rbyte(d, 1'b0);  chk(d == 8'd7, "R6 byte count", d, 7);
      for (int i = 0; i < 9; i++) begin
        recv_bit(b); chk(b == 1'b1, "R7 released after NACK", b, 1);
      end
      bus_stop();
    end

    // R4: random partial writes with read-back
    for (int t = 0; t < 8; t++) begin
      int n = 1 + int'($urandom % 6);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      wr_xfer(n);
      check_image("R4 partial write image");
      rd_xfer(NREG, "R4 partial write read-back");
    end

    chk(oe_glitch == 0, "R8 SDA drive changed with SCL high", oe_glitch, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule